// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of a high-resolution event timer. The channel holds a 64-bit comparator and compares it against a free-running main counter that is supplied from outside. When the counter reaches the comparator, the channel emits a one-cycle expiry pulse. The channel has four operating modes:

- **One-shot:** the channel fires once.
- **Periodic:** the channel re-loads itself by adding a stored period after each expiry.
- **64-bit:** the full counter and comparator take part in the match.
- **32-bit:** only the low word of the counter takes part. In this mode, a one-shot channel whose match lies beyond a counter wrap also fires when the low word wraps.

Software reaches the channel through three write strobes that share a 32-bit data bus. One strobe writes the configuration word. The other two write the low and high comparator words. The comparator and the configuration are read back as plain outputs.

A self-clearing set-value bit in the configuration decides how comparator writes land in periodic mode. When the bit is clear, a write only programs the period. When the bit is set, the write also loads the comparator directly. Routing of the expiry to an interrupt line and the address decoding of the register file belong to the surrounding block.

Top module: `evt_cmp_channel`

## Requirements
- R1: In periodic mode with a non-zero period, each match adds the period to the comparator. The new comparator lies after the counter value that matched. "After" means the signed difference comparator minus counter is positive, 64 bits wide in 64-bit mode.
- R2: In 32-bit mode (config bit 3), only the low 32 counter bits are compared. A periodic advance wraps the comparator modulo 2^32, and the after test is done on 32-bit signed differences.
- R3: While 32-bit mode is set, the high 32 bits of the comparator and of the period read as zero. Entering the mode clears them, and a high comparator write leaves them at zero.
- R4: This rule applies when the channel is armed in 32-bit one-shot mode and the low comparator word is below the low counter word (unsigned). In that case a hidden wrap flag is set, and the channel fires once when the low counter word is 0xFFFFFFFF. That event clears the flag, and the channel then fires again on the real match. No wrap event occurs otherwise.
- R5: In periodic mode (config bit 1), a comparator write changes the comparator only if the set-value bit (config bit 2) is 1. Every such write updates the period. Any comparator write clears the set-value bit.
- R6: Every value written into the period has its top bit forced to 0. That top bit is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R7: The following events arm the channel:
  - the enable bit (config bit 0) going from 0 to 1;
  - a comparator write while the global enable is high;
  - the global enable rising while the channel is enabled.

  Clearing the enable bit cancels the pending event. No event is produced while the global enable is low.
- R8: After reset, the comparator is all ones, the configuration is 0, the period is 0, the wrap flag is clear and no pulse is output.
- R9: This rule covers the armed, enabled channel while the global enable is high. If the counter equals the comparator on a clock edge, the expiry output is high for exactly the next cycle. A one-shot channel then disarms. An edge that carries any register write performs no compare.
- R10: A low comparator write leaves the high word unchanged, and a high write leaves the low word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | Current main-counter value |
| glb_en_i | input | 1 | Global enable of counting and events |
| cfg_we_i | input | 1 | Configuration write strobe |
| cmp_lo_we_i | input | 1 | Comparator low-word write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-word write strobe |
| wdata_i | input | 32 | Write data shared by the three strobes |
| expire_o | output | 1 | One-cycle expiry pulse |
| cmp_o | output | 64 | Comparator readback |
| cfg_o | output | 4 | Configuration readback: bit 0 enable, bit 1 periodic, bit 2 set-value, bit 3 32-bit mode |

## Verification
The assertions assume the following about the inputs:

- At most one write strobe is active per cycle, so the configuration and comparator paths never compete.
- Matches are found by equality, so the counter is assumed to step by one across any comparator value that matters.

The stimulus respects both assumptions. It issues writes one at a time and holds the counter still during them. It moves the counter in unit steps through every window in which an event is expected. Counter jumps are made only while the channel is disabled, or only to values whose comparators have already fired.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int unsigned CFG_W = 4;

  typedef struct packed {
    logic mode32;
    logic set_val;
    logic periodic;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
  import evt_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 lo_we_i,
  input  logic                 hi_we_i,
  input  logic [CNT_W/2-1:0]   wdata_i,
  input  logic                 adv_i,
  output logic [CNT_W-1:0]     cmp_o,
  output logic [CNT_W-1:0]     per_o,
  output chan_cfg_t            cfg_o,
  output logic [CNT_W-1:0]     cmp_d_o,
  output chan_cfg_t            cfg_d_o
);
  localparam int unsigned H = CNT_W / 2;

  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d, sum;
  chan_cfg_t        cfg_q, cfg_d;
  logic             upd_cmp;

  always_comb begin
    cfg_d   = cfg_q;
    cmp_d   = cmp_q;
    per_d   = per_q;
    sum     = cmp_q + per_q;
    upd_cmp = !cfg_q.periodic || cfg_q.set_val;
    if (adv_i) begin
      cmp_d = cfg_q.mode32 ? {{H{1'b0}}, sum[H-1:0]} : sum;
    end
    if (cfg_we_i) begin
      cfg_d = chan_cfg_t'(wdata_i[CFG_W-1:0]);
      if (cfg_d.mode32) begin
        cmp_d[CNT_W-1:H]   = '0;
        per_d[CNT_W-1:H-1] = '0;
      end
    end else if (lo_we_i || hi_we_i) begin
      cfg_d.set_val = 1'b0;
      if (lo_we_i) begin
        if (upd_cmp) cmp_d[H-1:0] = wdata_i;
        if (cfg_q.periodic)
          per_d[H-1:0] = cfg_q.mode32 ? {1'b0, wdata_i[H-2:0]} : wdata_i;
      end
      if (hi_we_i) begin
        if (upd_cmp && !cfg_q.mode32) cmp_d[CNT_W-1:H] = wdata_i;
        if (cfg_q.periodic)
          per_d[CNT_W-1:H] = cfg_q.mode32 ? '0 : {1'b0, wdata_i[H-2:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      per_q <= '0;
      cfg_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
      cfg_q <= cfg_d;
    end
  end

  assign cmp_o   = cmp_q;
  assign per_o   = per_q;
  assign cfg_o   = cfg_q;
  assign cmp_d_o = cmp_d;
  assign cfg_d_o = cfg_d;
endmodule

// File: rtl/evt_cmp_match.sv
module evt_cmp_match #(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             mode32_i,
  input  logic             armed_i,
  input  logic             wrap_i,
  input  logic             glb_en_i,
  input  logic             wr_any_i,
  output logic             wrap_hit_o,
  output logic             match_hit_o,
  output logic             adv_o
);
  localparam int unsigned H  = CNT_W / 2;
  localparam int unsigned NH = 2;

  logic [NH-1:0] eq_half;
  logic          active;

  for (genvar g = 0; g < NH; g++) begin : g_half
    assign eq_half[g] = (cnt_i[g*H +: H] == cmp_i[g*H +: H]);
  end

  assign active      = armed_i && glb_en_i && en_i && !wr_any_i;
  assign wrap_hit_o  = active && wrap_i && (&cnt_i[H-1:0]);
  assign match_hit_o = active && !wrap_i && (mode32_i ? eq_half[0] : &eq_half);
  assign adv_o       = match_hit_o && periodic_i && (per_i != '0);
endmodule

// File: rtl/evt_cmp_arm.sv
module evt_cmp_arm #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic               cfg_we_i,
  input  logic               cmp_we_i,
  input  logic               en_q_i,
  input  logic               en_d_i,
  input  logic               periodic_q_i,
  input  logic               oneshot32_d_i,
  input  logic [CNT_W/2-1:0] cmp_lo_d_i,
  input  logic [CNT_W/2-1:0] cnt_lo_i,
  input  logic               wrap_hit_i,
  input  logic               match_hit_i,
  output logic               armed_o,
  output logic               wrap_o
);
  logic glb_q, armed_q, wrap_q;
  logic en_rise, en_fall, arm_now, wrap_set;

  assign en_rise  = cfg_we_i && !en_q_i && en_d_i;
  assign en_fall  = cfg_we_i && en_q_i && !en_d_i;
  assign arm_now  = en_rise || (cmp_we_i && glb_en_i) || (!glb_q && en_q_i);
  // match lies beyond a wrap of the low counter word
  assign wrap_set = oneshot32_d_i && (cmp_lo_d_i < cnt_lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q   <= 1'b0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      glb_q <= glb_en_i;
      if (!glb_en_i || en_fall) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm_now) begin
        armed_q <= 1'b1;
        wrap_q  <= wrap_set;
      end else begin
        if (wrap_hit_i) wrap_q <= 1'b0;
        if (match_hit_i && !periodic_q_i) armed_q <= 1'b0;
      end
    end
  end

  assign armed_o = armed_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               glb_en_i,
  input  logic               cfg_we_i,
  input  logic               cmp_lo_we_i,
  input  logic               cmp_hi_we_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  output logic               expire_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [CFG_W-1:0]   cfg_o
);
  localparam int unsigned H = CNT_W / 2;

  logic [CNT_W-1:0] cmp_w, per_w, cmp_d_w;
  chan_cfg_t        cfg_w, cfg_d_w;
  logic             adv_w, wrap_hit_w, match_hit_w, armed_w, wrap_w;
  logic             cmp_we_w, wr_any_w, expire_q;

  assign cmp_we_w = cmp_lo_we_i || cmp_hi_we_i;
  assign wr_any_w = cmp_we_w || cfg_we_i;

  evt_cmp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_we_i(cfg_we_i),
    .lo_we_i (cmp_lo_we_i),
    .hi_we_i (cmp_hi_we_i),
    .wdata_i (wdata_i),
    .adv_i   (adv_w),
    .cmp_o   (cmp_w),
    .per_o   (per_w),
    .cfg_o   (cfg_w),
    .cmp_d_o (cmp_d_w),
    .cfg_d_o (cfg_d_w)
  );

  evt_cmp_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i      (count_i),
    .cmp_i      (cmp_w),
    .per_i      (per_w),
    .en_i       (cfg_w.en),
    .periodic_i (cfg_w.periodic),
    .mode32_i   (cfg_w.mode32),
    .armed_i    (armed_w),
    .wrap_i     (wrap_w),
    .glb_en_i   (glb_en_i),
    .wr_any_i   (wr_any_w),
    .wrap_hit_o (wrap_hit_w),
    .match_hit_o(match_hit_w),
    .adv_o      (adv_w)
  );

  evt_cmp_arm #(.CNT_W(CNT_W)) u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .glb_en_i     (glb_en_i),
    .cfg_we_i     (cfg_we_i),
    .cmp_we_i     (cmp_we_w),
    .en_q_i       (cfg_w.en),
    .en_d_i       (cfg_d_w.en),
    .periodic_q_i (cfg_w.periodic),
    .oneshot32_d_i(cfg_d_w.mode32 && !cfg_d_w.periodic),
    .cmp_lo_d_i   (cmp_d_w[H-1:0]),
    .cnt_lo_i     (count_i[H-1:0]),
    .wrap_hit_i   (wrap_hit_w),
    .match_hit_i  (match_hit_w),
    .armed_o      (armed_w),
    .wrap_o       (wrap_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) expire_q <= 1'b0;
    else         expire_q <= wrap_hit_w || match_hit_w;
  end

  assign expire_o = expire_q;
  assign cmp_o    = cmp_w;
  assign cfg_o    = cfg_w;
endmodule

// File: rtl/evt_cmp_checker.sv
module evt_cmp_checker #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             glb_en_i,
  input logic             cfg_we_i,
  input logic             cmp_lo_we_i,
  input logic             cmp_hi_we_i,
  input logic             expire_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic [3:0]       cfg_o,
  input logic             adv_i,
  input logic             per_top_i,
  input logic             per_half_top_i,
  input logic             per_hi_zero_i
);
  localparam int unsigned H = CNT_W / 2;

  AST_PERIODIC_AFTER64: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(adv_i) && !cfg_o[3] |-> $signed(cmp_o - $past(count_i)) > 0); // R1

  AST_PERIODIC_AFTER32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(adv_i) && cfg_o[3] |-> $signed(cmp_o[H-1:0] - $past(count_i[H-1:0])) > 0); // R2

  AST_MODE32_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[3] |-> (cmp_o[CNT_W-1:H] == '0) && per_hi_zero_i); // R3

  AST_PERIOD_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_top_i && (!cfg_o[3] || !per_half_top_i)); // R6

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i |=> !cfg_o[2]); // R5

  AST_EXPIRE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(glb_en_i) && $past(cfg_o[0])); // R7

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[0] |=> !expire_o); // R7

  AST_ONESHOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !cfg_o[1] && !cfg_o[3] |=> !expire_o); // R9
endmodule

bind evt_cmp_channel evt_cmp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .count_i       (count_i),
  .glb_en_i      (glb_en_i),
  .cfg_we_i      (cfg_we_i),
  .cmp_lo_we_i   (cmp_lo_we_i),
  .cmp_hi_we_i   (cmp_hi_we_i),
  .expire_o      (expire_o),
  .cmp_o         (cmp_o),
  .cfg_o         (cfg_o),
  .adv_i         (adv_w),
  .per_top_i     (per_w[CNT_W-1]),
  .per_half_top_i(per_w[CNT_W/2-1]),
  .per_hi_zero_i (per_w[CNT_W-1:CNT_W/2] == '0)
);

// File: tb/evt_cmp_channel_tb_top.sv
module evt_cmp_channel_tb_top;
  localparam int W = 64;
  localparam logic [31:0] C_EN = 32'h1, C_PER = 32'h2, C_SV = 32'h4, C_M32 = 32'h8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  count = '0;
  logic          glb_en = 1'b0;
  logic          cfg_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [31:0]   wdata = '0;
  logic          expire;
  logic [W-1:0]  cmp;
  logic [3:0]    cfg;
  int            n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  evt_cmp_channel #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .glb_en_i(glb_en),
    .cfg_we_i(cfg_we), .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we),
    .wdata_i(wdata), .expire_o(expire), .cmp_o(cmp), .cfg_o(cfg)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    wdata = d; cfg_we = 1'b1; step(); cfg_we = 1'b0;
  endtask
  task automatic wr_lo(input logic [31:0] d);
    wdata = d; lo_we = 1'b1; step(); lo_we = 1'b0;
  endtask
  task automatic wr_hi(input logic [31:0] d);
    wdata = d; hi_we = 1'b1; step(); hi_we = 1'b0;
  endtask
  task automatic wr_cmp(input logic [W-1:0] v);
    wr_lo(v[31:0]); wr_hi(v[63:32]);
  endtask

  function automatic bit exp_hit(input logic [W-1:0] c, input logic [W-1:0] e0,
                                 input logic [W-1:0] per, input logic [W-1:0] e1, input bit use_e1);
    bit h;
    h = (c == e0) || (per != 0 && c > e0 && ((c - e0) % per) == 0);
    return h || (use_e1 && c == e1);
  endfunction

  // next comparator after periodic run ending at count 'last'
  function automatic logic [W-1:0] next_cmp(input logic [W-1:0] last, input logic [W-1:0] e0,
                                            input logic [W-1:0] per);
    return e0 + per * ((last - e0) / per + 1);
  endfunction

  task automatic run_chk(input logic [W-1:0] start, input int n, input logic [W-1:0] e0,
                         input logic [W-1:0] per, input logic [W-1:0] e1, input bit use_e1,
                         input string tag);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] c;
      c = start + W'(i);
      count = c;
      step();
      chk(tag, {63'd0, expire}, {63'd0, exp_hit(c, e0, per, e1, use_e1)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] base, tgt, last, e0, cnt;
    logic [W-1:0] per;
    int d;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R8 cmp reset", cmp, '1);
    chk("R8 cfg reset", {60'd0, cfg}, '0);
    chk("R8 expire reset", {63'd0, expire}, '0);
    glb_en = 1'b1;

    // one-shot 64-bit, halves
    base = {8'h01, 24'($urandom), $urandom};
    d = 5 + int'($urandom % 20);
    tgt = base + W'(d);
    count = base;
    wr_cfg(C_EN);
    wr_hi(tgt[63:32]);
    chk("R10 hi keeps lo", cmp, {tgt[63:32], 32'hFFFF_FFFF});
    wr_lo(tgt[31:0]);
    chk("R10 lo keeps hi", cmp, tgt);
    run_chk(base + 1, d + 10, tgt, 0, 0, 1'b0, "R9 oneshot64");

    for (int k = 0; k < 6; k++) begin
      base = {8'h01, 24'($urandom), $urandom};
      d = 1 + int'($urandom % 30);
      tgt = base + W'(d);
      count = base;
      wr_cmp(tgt);
      run_chk(base + 1, d + 4, tgt, 0, 0, 1'b0, "R9 random oneshot");
    end

    // global enable gating and re-arm
    base = count;
    glb_en = 1'b0;
    wr_cfg(0);
    wr_cmp(base + 10);
    wr_cfg(C_EN);
    run_chk(base + 1, 15, 0, 0, 0, 1'b0, "R7 glb low silent");
    wr_cmp(base + 30);
    glb_en = 1'b1;
    run_chk(base + 16, 25, base + 30, 0, 0, 1'b0, "R7 glb rise arms");
    wr_cmp(base + 60);
    wr_cfg(0);
    run_chk(base + 41, 30, 0, 0, 0, 1'b0, "R7 disable cancels");
    wr_cfg(C_EN);
    wr_cmp(base + 80);
    run_chk(base + 71, 15, base + 80, 0, 0, 1'b0, "R7 write rearms");

    // periodic 64-bit with set-value
    base = count;
    per = W'(3 + $urandom % 9);
    tgt = base + 10;
    wr_cfg(C_PER | C_SV);
    wr_lo(tgt[31:0]);
    chk("R5 setval clears", {60'd0, cfg}, {60'd0, C_PER[3:0]});
    wr_cfg(C_PER | C_SV);
    wr_hi(tgt[63:32]);
    chk("R5 setval loads cmp", cmp, tgt);
    wr_lo(per[31:0]);
    wr_hi(32'h0);
    chk("R5 period write leaves cmp", cmp, tgt);
    wr_cfg(C_EN | C_PER);
    run_chk(base + 1, 40, tgt, per, 0, 1'b0, "R1 periodic64");
    last = base + 40;
    chk("R1 cmp advanced", cmp, next_cmp(last, tgt, per));

    // period top bit forced (64-bit)
    base = count;
    tgt = base + 5;
    wr_cfg(C_PER | C_SV);
    wr_lo(tgt[31:0]);
    wr_cfg(C_PER | C_SV);
    wr_hi(tgt[63:32]);
    wr_lo(32'h3);
    wr_hi(32'hFFFF_FFFF);
    wr_cfg(C_EN | C_PER);
    run_chk(base + 1, 10, tgt, 0, 0, 1'b0, "R6 single hit");
    chk("R6 period msb cleared", cmp, tgt + 64'h7FFF_FFFF_0000_0003);

    // 32-bit mode truncation
    wr_cfg(C_M32);
    chk("R3 enter clears high", {32'd0, cmp[63:32]}, '0);
    wr_hi(32'hABCD);
    chk("R3 hi write ignored", {32'd0, cmp[63:32]}, '0);

    // 32-bit periodic across wrap, period written with bit31 set
    cnt = {8'h02, 24'($urandom), 32'hFFFF_FFF0};
    count = cnt;
    wr_cfg(C_M32 | C_PER | C_SV);
    wr_lo(32'hFFFF_FFFE);
    wr_lo(32'h8000_0005);
    chk("R2 cmp low only", cmp, 64'h0000_0000_FFFF_FFFE);
    wr_cfg(C_EN | C_PER | C_M32);
    e0 = {cnt[63:32], 32'hFFFF_FFFE};
    run_chk(cnt + 1, 30, e0, 5, 0, 1'b0, "R2 periodic32 wrap");
    last = cnt + 30;
    chk("R2 cmp wraps mod 2^32", cmp, {32'd0, 32'(next_cmp(last, e0, 5))});

    // wrap flag in 32-bit one-shot
    cnt = {8'h03, 24'($urandom), 32'hFFFF_FFF0};
    count = cnt;
    wr_cfg(C_M32);
    wr_lo(32'h10);
    wr_cfg(C_EN | C_M32);
    run_chk(cnt + 1, 40, cnt + 32, 0, {cnt[63:32], 32'hFFFF_FFFF}, 1'b1, "R4 wrap then match");

    cnt = {8'h04, 24'($urandom), 32'hFFFF_FFE0};
    count = cnt;
    wr_cfg(C_M32);
    wr_lo(32'hFFFF_FFF8);
    wr_cfg(C_EN | C_M32);
    run_chk(cnt + 1, 40, {cnt[63:32], 32'hFFFF_FFF8}, 0, 0, 1'b0, "R4 no wrap event");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule